// File: doc/BRIEF.md
# Set-Associative Data Translation Probe

This block answers one question without touching any other state: what physical address does a data effective address map to, and would the access be allowed? It holds a small set-associative translation buffer. Each entry pairs a match word, which holds a page tag and a valid bit, with a translate word, which holds a physical page number, a cache-inhibit flag and four access-enable flags. A lookup strobe latches a result one cycle later. The result gives the physical address, a hit flag, a permission-denied flag and a cache-inhibit flag.

When translation is switched off or the unit is absent, the address passes through unchanged. Cache-inhibit then marks the upper half of the address space. A miss or a denied access returns no translation and raises no fault, so a debugger or monitor can use the probe freely. Entries are loaded through a synchronous write port that selects a set, a way and either the match or the translate word.

Top module: `dtlb_probe`

## Requirements
- R1: When `mmu_en` or `mmu_present` is low, a lookup returns `rsp_hit`=1, `rsp_denied`=0 and `rsp_paddr` equal to `vaddr`.
- R2: In that pass-through case, `rsp_ci` is 1 exactly when `vaddr` is at or above 0x80000000.
- R3: With translation active, the set is `vaddr[18:13]`, and a way matches only when its match word has bit 0 (valid) set and bits [31:19] (tag) equal to `vaddr[31:19]`.
- R4: When more than one way of the selected set matches, the highest-numbered way supplies the result.
- R5: The permission check uses translate word bit 4 (supervisor read) or bit 5 (supervisor write) when `supervisor`=1. It uses bit 2 (user read) or bit 3 (user write) when `supervisor`=0. `is_write` chooses between read and write.
- R6: A miss returns hit=0, denied=0, paddr=0 and ci=0. A matching way whose permission check fails returns hit=0, denied=1, paddr=0 and ci=0.
- R7: A permitted hit returns `rsp_paddr` = {translate[31:13], vaddr[12:0]}, and `rsp_ci` equals translate bit 1.
- R8: `rsp_valid` is high for exactly the cycle after a cycle with `req` high. The other outputs change only on such a cycle and otherwise hold their values.
- R9: An entry write is visible to a lookup issued in the following cycle. A lookup issued in the same cycle as the write sees the old contents. For a match write, data bit 0 is the valid bit and bits [31:19] are the tag.
- R10: Reset clears every valid bit and every output, so every translated lookup after reset misses until an entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_set | input | 6 | Set index of the written entry |
| wr_way | input | 1 | Way of the written entry |
| wr_xlat | input | 1 | 1 writes the translate word, 0 writes the match word |
| wr_data | input | 32 | Entry write data |
| req | input | 1 | Lookup strobe |
| vaddr | input | 32 | Effective address to translate |
| is_write | input | 1 | Check write permission instead of read |
| supervisor | input | 1 | Privilege mode of the access |
| mmu_en | input | 1 | Translation enabled |
| mmu_present | input | 1 | Translation unit present |
| rsp_valid | output | 1 | Result strobe, one cycle after `req` |
| rsp_hit | output | 1 | A translation was produced |
| rsp_paddr | output | 32 | Physical address, zero when there is no translation |
| rsp_denied | output | 1 | A way matched but the permission check failed |
| rsp_ci | output | 1 | Cache-inhibit for the translated access |

## Verification
A corrupted tag, valid bit or translate word shows up on the very next `rsp_valid` for any lookup into that set. It appears as a wrong miss or hit, a flipped denied flag, or a wrong upper address. The page offset and the pass-through path never depend on stored state, so any error there points directly at the datapath. Way priority is exposed by loading two matching ways with different page numbers. A write-before-read race is exposed by issuing a lookup in the same cycle as the write that invalidates the entry it reads.

// File: rtl/dtlb_probe.sv
module dtlb_probe #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 6,
  parameter int WAYS      = 2,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SETS     = 1 << SET_BITS,
  localparam int TAG_W    = ADDR_W - PAGE_BITS - SET_BITS,
  localparam int PPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              wr_xlat,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              req,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_write,
  input  logic              supervisor,
  input  logic              mmu_en,
  input  logic              mmu_present,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_denied,
  output logic              rsp_ci
);
  localparam int B_V = 0, B_CI = 1, B_URE = 2, B_UWE = 3, B_SRE = 4, B_SWE = 5;

  logic [TAG_W-1:0]  tag_q  [WAYS][SETS];
  logic [ADDR_W-1:0] xlat_q [WAYS][SETS];
  logic [WAYS-1:0]   vld_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en && !wr_xlat) begin
      vld_q[wr_set][wr_way] <= wr_data[B_V];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_xlat) xlat_q[wr_way][wr_set] <= wr_data;
      else         tag_q[wr_way][wr_set]  <= wr_data[ADDR_W-1 -: TAG_W];
    end
  end

  wire [SET_BITS-1:0] set_idx = vaddr[PAGE_BITS +: SET_BITS];
  wire [TAG_W-1:0]    vtag    = vaddr[ADDR_W-1 -: TAG_W];
  wire                bypass  = !(mmu_en && mmu_present);

  logic             found;
  logic [WAY_W-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[set_idx][w] && tag_q[w][set_idx] == vtag) begin
        found = 1'b1;
        sel   = WAY_W'(w);
      end
    end
  end

  wire [ADDR_W-1:0] xl    = xlat_q[sel][set_idx];
  wire              allow = supervisor ? (is_write ? xl[B_SWE] : xl[B_SRE])
                                       : (is_write ? xl[B_UWE] : xl[B_URE]);
  wire              grant = found && allow;
  wire [ADDR_W-1:0] tpa   = {xl[ADDR_W-1 -: PPN_W], vaddr[PAGE_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_paddr  <= '0;
      rsp_denied <= 1'b0;
      rsp_ci     <= 1'b0;
    end else begin
      rsp_valid <= req;
      if (req) begin
        rsp_hit    <= bypass || grant;
        rsp_denied <= !bypass && found && !allow;
        rsp_paddr  <= bypass ? vaddr : (grant ? tpa : '0);
        rsp_ci     <= bypass ? vaddr[ADDR_W-1] : (grant && xl[B_CI]);
      end
    end
  end

  a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit));
  a_r1_bypass_identity: assert property (@(posedge clk) disable iff (!rst_n)
    req && !(mmu_en && mmu_present) |=> rsp_hit && !rsp_denied && rsp_paddr == $past(vaddr));
  a_r2_bypass_ci: assert property (@(posedge clk) disable iff (!rst_n)
    req && !(mmu_en && mmu_present) |=> rsp_ci == $past(vaddr[ADDR_W-1]));
  a_r6_no_translation_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_paddr == '0 && !rsp_ci);
  a_r6_hit_denied_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_denied));
  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(vaddr[PAGE_BITS-1:0]));
endmodule

// File: tb/dtlb_probe_bench.sv
module dtlb_probe_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_way = 0, wr_xlat = 0;
  logic [5:0] wr_set = 0;
  logic [31:0] wr_data = 0, vaddr = 0;
  logic req = 0, is_write = 0, supervisor = 0, mmu_en = 1, mmu_present = 1;
  logic rsp_valid, rsp_hit, rsp_denied, rsp_ci;
  logic [31:0] rsp_paddr;
  int checks = 0, bad = 0;

  always #10 clk = ~clk;

  dtlb_probe u_dtlb_probe (.clk, .rst_n, .wr_en, .wr_set, .wr_way, .wr_xlat,
    .wr_data, .req, .vaddr, .is_write, .supervisor, .mmu_en, .mmu_present,
    .rsp_valid, .rsp_hit, .rsp_paddr, .rsp_denied, .rsp_ci);

  // vaddr, wr, sup, en, present, hit, denied, ci, paddr
  localparam logic [70:0] VEC [14] = '{
    {32'h0528A123, 1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b1, 32'h2468A123},
    {32'h0528A123, 1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0, 32'h0},
    {32'h0528A123, 1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1, 32'h2468A123},
    {32'h0528A123, 1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1, 32'h2468A123},
    {32'hFFF93FFF, 1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'hFFFFFFFF},
    {32'h0530A123, 1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0, 32'h0},
    {32'h0528C123, 1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0, 32'h0},
    {32'h000A8010, 1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0, 32'h00000010},
    {32'h000A8010, 1'b0,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0, 32'h0},
    {32'h000A8010, 1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0, 32'h0},
    {32'h80000000, 1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1, 32'h80000000},
    {32'h7FFFFFFC, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0, 32'h7FFFFFFC},
    {32'h0528A123, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 32'h0528A123},
    {32'h000A8010, 1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0, 32'h000A8010}
  };

  task automatic check(input string req_id, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  task automatic put(input logic [5:0] s, input logic w, input logic x, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_set = s; wr_way = w; wr_xlat = x; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic probe(input logic [31:0] a, input logic wr, input logic sup,
                       input logic en, input logic pr);
    @(negedge clk);
    req = 1; vaddr = a; is_write = wr; supervisor = sup; mmu_en = en; mmu_present = pr;
    @(negedge clk);
    req = 0;
  endtask

  function automatic logic [34:0] pack(input logic v, input logic h, input logic d,
                                       input logic c, input logic [31:0] p);
    return {v, h, d, c, p};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr), 35'h0);
    rst_n = 1;
    probe(32'h0528A123, 0, 1, 1, 1);
    check("R10 miss after reset", pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr),
          pack(1, 0, 0, 0, 32'h0));

    // R3 R5 R7 entries
    put(6'd5, 0, 0, {13'h0A5, 19'h1});
    put(6'd5, 0, 1, {19'h12345, 13'h36});
    put(6'd9, 0, 0, {13'h1FFF, 19'h1});
    put(6'd9, 0, 1, {19'h00001, 13'h3C});
    put(6'd9, 1, 0, {13'h1FFF, 19'h1});
    put(6'd9, 1, 1, {19'h7FFFF, 13'h3C});
    put(6'd20, 0, 0, {13'h001, 19'h1});
    put(6'd20, 0, 1, {19'h00000, 13'h04});

    for (int i = 0; i < 14; i++) begin
      probe(VEC[i][70:39], VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35]);
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", i),
            pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr),
            pack(1, VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0]));
    end

    // R8: outputs hold when no request
    probe(32'hFFF93FFF, 0, 0, 1, 1);
    @(negedge clk);
    check("R8 hold without req", pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr),
          pack(0, 1, 0, 0, 32'hFFFFFFFF));

    // R4: remove the higher way, lower way now wins
    put(6'd9, 1, 0, 32'h0);
    probe(32'hFFF93FFF, 0, 0, 1, 1);
    check("R4 lower way after invalidate", pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr),
          pack(1, 1, 0, 0, 32'h00003FFF));

    // R9: same-cycle write sees old, next cycle sees new
    @(negedge clk);
    wr_en = 1; wr_set = 6'd5; wr_way = 0; wr_xlat = 0; wr_data = {13'h0A5, 19'h0};
    req = 1; vaddr = 32'h0528A123; is_write = 0; supervisor = 0; mmu_en = 1; mmu_present = 1;
    @(negedge clk);
    wr_en = 0; req = 0;
    check("R9 same-cycle old contents", pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr),
          pack(1, 1, 0, 1, 32'h2468A123));
    probe(32'h0528A123, 0, 0, 1, 1);
    check("R9 next-cycle new contents", pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr),
          pack(1, 0, 0, 0, 32'h0));

    // R10: reset clears stored valid bits
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    probe(32'h000A8010, 0, 0, 1, 1);
    check("R10 miss after second reset", pack(rsp_valid, rsp_hit, rsp_denied, rsp_ci, rsp_paddr),
          pack(1, 0, 0, 0, 32'h0));

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule